// File: doc/BRIEF.md
# Card-side initialization and selection controller

This block is the device-side controller that walks a managed-flash card from power-up to the state in which it can move data. It receives commands that are already decoded, each as a 6-bit index, a 32-bit argument and a one-cycle valid strobe. For each command it decides whether the command is legal in the present state. A legal command that answers produces a registered response word. The block reports its state as a 4-bit code and tracks the selected data bus width. It also keeps the operating-condition word, the assigned card address and the per-line pull-up enables.

Boot entry has two triggers. One is a reset command that carries a special argument and arrives before the first operating-condition query. The other is the command line held low while the device is idle and has not yet been queried. The condition word's top bit reads low while a modelled power-up routine runs, and the host cannot change the stored word. A selected device leaves the transfer state when it sees a select command with any other address. Address zero is reserved: it deselects every device and cannot be assigned.

Top module: `mmc_dev_state_ctrl`

## Requirements
- R1: After reset the state code is 0 (idle), the address is 0x0001, the width code is 0 (1-bit), the pull-up vector is 0xFF, and both the response strobe and the illegal flag are low.
- R2: Index 1 in idle answers with bit 31 equal to 0 while fewer than PWRUP_CYCLES cycles have passed since reset, and the state stays 0. Once the routine has finished, bit 31 is 1 and the state becomes 1 (ready).
- R3: Bits 30:0 of the index-1 response always equal OCR_BASE, whatever the argument, so the host cannot alter the condition word.
- R4: Index 0 with argument 0xFFFFFFFA, received in idle with no index 1 since the last reset or index 0, enters state 15 (boot) with no response. Received after an index 1, the same command is an ordinary reset to idle.
- R5: cmd_line_low held high in idle, before any index 1, enters state 15. Releasing it returns a boot entered this way to state 0.
- R6: Index 2 in ready moves to state 2 and answers with CID_WORD. Index 3 in state 2 with a nonzero arg[31:16] stores that address, moves to state 3 and answers. Index 3 with address 0x0000 is illegal.
- R7: Index 7 in state 3 with arg[31:16] equal to the stored address moves to state 4 and answers. With any other address it changes nothing, gives no response and does not set the illegal flag.
- R8: Index 7 in state 4 with arg[31:16] different from the stored address, 0x0000 included, moves to state 3 and answers. With the device's own address it is illegal.
- R9: Index 6 in state 4 sets the width code to arg[1:0] and answers. Code 0 (1-bit) gives pull-ups 0xFF. Code 1 (4-bit) turns lines 1 and 2 off, giving 0xF9. Code 2 (8-bit) also turns lines 4 to 7 off, giving 0x09. Code 3 is illegal and leaves the width unchanged.
- R10: A command that is not legal in the present state, unknown indices included, gives no response, leaves the state unchanged and sets the illegal flag. The next accepted command clears the flag.
- R11: Index 0 that is not a boot request returns any state to 0 with no response. It also restores the address to 0x0001, the width code to 0 and the pull-ups to 0xFF.
- R12: For indices 3, 6 and 7, the status response holds the state code from before the command in bits 12:9, with every other bit zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| cmd_line_low | input | 1 | High while the command line is held low |
| rsp_valid | output | 1 | Response word valid, one cycle |
| rsp_data | output | 32 | Response word |
| state_code | output | 4 | Current state code |
| illegal_cmd | output | 1 | Last rejected command flag |
| card_addr | output | 16 | Stored card address |
| bus_width | output | 2 | Width code: 0 1-bit, 1 4-bit, 2 8-bit |
| pullup_en | output | 8 | Pull-up enable per data line |

## Verification
Every command effect is registered on the clock edge that samples the strobe. This covers the state code, the response, the illegal flag, the address, the width and the pull-ups, so all of them are due exactly one cycle after the command. The bench raises the strobe on a falling edge, drops it on the next falling edge and reads the outputs there, half a cycle after the capturing edge. Hold-driven boot entry and exit also take one edge, and the bench idles two cycles before sampling them. The busy bit is probed immediately after reset and again after waiting well past PWRUP_CYCLES.

// File: rtl/mmc_dev_pkg.sv
package mmc_dev_pkg;
  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_READY = 4'd1,
    ST_IDENT = 4'd2,
    ST_STBY  = 4'd3,
    ST_XFER  = 4'd4,
    ST_BOOT  = 4'd15
  } card_state_e;

  localparam logic [5:0] IDX_RESET  = 6'd0;
  localparam logic [5:0] IDX_OPCOND = 6'd1;
  localparam logic [5:0] IDX_ID     = 6'd2;
  localparam logic [5:0] IDX_ADDR   = 6'd3;
  localparam logic [5:0] IDX_WIDTH  = 6'd6;
  localparam logic [5:0] IDX_SELECT = 6'd7;

  localparam logic [31:0] BOOT_ARG  = 32'hFFFF_FFFA;
  localparam logic [15:0] ADDR_DEF  = 16'h0001;

  localparam logic [1:0] W_1BIT = 2'd0;
  localparam logic [1:0] W_4BIT = 2'd1;
  localparam logic [1:0] W_8BIT = 2'd2;
endpackage

// File: rtl/pwrup_timer.sv
module pwrup_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (cnt_q != LIMIT) begin
      cnt_q  <= cnt_q + 1'b1;
      done_o <= (cnt_q + 1'b1) == LIMIT;
    end
  end

  a_r2_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);
endmodule

// File: rtl/bus_width_ctrl.sv
module bus_width_ctrl
  import mmc_dev_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restore_i,
  input  logic             set_i,
  input  logic [1:0]       code_i,
  output logic [1:0]       width_o,
  output logic [LINES-1:0] pullup_o
);
  logic [1:0] width_d;

  always_comb begin
    width_d = width_o;
    if (restore_i)  width_d = W_1BIT;
    else if (set_i) width_d = code_i;
  end

  always_ff @(posedge clk) begin
    if (rst) width_o <= W_1BIT;
    else     width_o <= width_d;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    localparam bit NARROW_OFF = (i == 1) || (i == 2);
    localparam bit WIDE_OFF   = (i != 0) && (i != 3);
    always_ff @(posedge clk) begin
      if (rst) pullup_o[i] <= 1'b1;
      else     pullup_o[i] <= !((width_d == W_4BIT && NARROW_OFF) ||
                                (width_d == W_8BIT && WIDE_OFF));
    end
  end

  a_r9_width_stable: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !restore_i) |=> $stable(width_o));
  a_r9_line0_pulled: assert property (@(posedge clk) disable iff (rst)
    pullup_o[0] && pullup_o[3]);
  a_r11_restore_narrow: assert property (@(posedge clk) disable iff (rst)
    restore_i |=> (width_o == W_1BIT) && (&pullup_o));
endmodule

// File: rtl/card_state_fsm.sv
module card_state_fsm
  import mmc_dev_pkg::*;
#(
  parameter logic [30:0] OCR_BASE = 31'h00FF_8080,
  parameter logic [31:0] CID_WORD = 32'hFE01_4D4D
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  input  logic [5:0]  cmd_idx,
  input  logic [31:0] cmd_arg,
  input  logic        line_low,
  input  logic        pwr_done,
  output logic [3:0]  state_o,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        illegal_o,
  output logic [15:0] addr_o,
  output logic        width_set,
  output logic        bus_restore
);
  card_state_e state_q, state_d;
  logic        op_seen_q, op_seen_d;
  logic        hold_q, hold_d;
  logic [15:0] addr_d;
  logic        accept, respond, bad;
  logic [31:0] rsp_d;
  logic [15:0] arg_addr;
  logic        addr_match;
  logic [31:0] status_word;

  assign arg_addr    = cmd_arg[31:16];
  assign addr_match  = arg_addr == addr_o;
  assign status_word = {19'd0, state_q, 9'd0};

  always_comb begin
    state_d     = state_q;
    op_seen_d   = op_seen_q;
    hold_d      = hold_q;
    addr_d      = addr_o;
    accept      = 1'b0;
    respond     = 1'b0;
    bad         = 1'b0;
    rsp_d       = '0;
    width_set   = 1'b0;
    bus_restore = 1'b0;
    if (cmd_valid) begin
      unique case (cmd_idx)
        IDX_RESET: begin
          accept      = 1'b1;
          bus_restore = 1'b1;
          addr_d      = ADDR_DEF;
          hold_d      = 1'b0;
          op_seen_d   = 1'b0;
          if (cmd_arg == BOOT_ARG && state_q == ST_IDLE && !op_seen_q)
            state_d = ST_BOOT;
          else
            state_d = ST_IDLE;
        end
        IDX_OPCOND: begin
          if (state_q == ST_IDLE) begin
            accept    = 1'b1;
            respond   = 1'b1;
            op_seen_d = 1'b1;
            rsp_d     = {pwr_done, OCR_BASE};
            if (pwr_done) state_d = ST_READY;
          end else bad = 1'b1;
        end
        IDX_ID: begin
          if (state_q == ST_READY) begin
            accept  = 1'b1;
            respond = 1'b1;
            rsp_d   = CID_WORD;
            state_d = ST_IDENT;
          end else bad = 1'b1;
        end
        IDX_ADDR: begin
          if (state_q == ST_IDENT && arg_addr != 16'h0000) begin
            accept  = 1'b1;
            respond = 1'b1;
            rsp_d   = status_word;
            addr_d  = arg_addr;
            state_d = ST_STBY;
          end else bad = 1'b1;
        end
        IDX_SELECT: begin
          if (state_q == ST_STBY) begin
            if (addr_match && arg_addr != 16'h0000) begin
              accept  = 1'b1;
              respond = 1'b1;
              rsp_d   = status_word;
              state_d = ST_XFER;
            end
          end else if (state_q == ST_XFER) begin
            if (!addr_match) begin
              accept  = 1'b1;
              respond = 1'b1;
              rsp_d   = status_word;
              state_d = ST_STBY;
            end else bad = 1'b1;
          end else bad = 1'b1;
        end
        IDX_WIDTH: begin
          if (state_q == ST_XFER && cmd_arg[1:0] != 2'd3) begin
            accept    = 1'b1;
            respond   = 1'b1;
            rsp_d     = status_word;
            width_set = 1'b1;
          end else bad = 1'b1;
        end
        default: bad = 1'b1;
      endcase
    end else begin
      if (line_low && state_q == ST_IDLE && !op_seen_q) begin
        state_d = ST_BOOT;
        hold_d  = 1'b1;
      end else if (state_q == ST_BOOT && hold_q && !line_low) begin
        state_d = ST_IDLE;
        hold_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      op_seen_q <= 1'b0;
      hold_q    <= 1'b0;
      addr_o    <= ADDR_DEF;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      illegal_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      op_seen_q <= op_seen_d;
      hold_q    <= hold_d;
      addr_o    <= addr_d;
      rsp_valid <= respond;
      if (respond) rsp_data <= rsp_d;
      if (bad)         illegal_o <= 1'b1;
      else if (accept) illegal_o <= 1'b0;
    end
  end

  assign state_o = state_q;

  a_r10_no_rsp_when_illegal: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !illegal_o);
  a_r8_deselect_zero: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_idx == IDX_SELECT && state_o == ST_XFER && cmd_arg[31:16] == 16'h0000)
    |=> state_o == ST_STBY);
  a_r7_select_match: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_idx == IDX_SELECT && state_o == ST_STBY && cmd_arg[31:16] == addr_o)
    |=> state_o == ST_XFER);
  a_r4_boot_silent: assert property (@(posedge clk) disable iff (rst)
    state_o == ST_BOOT |-> !rsp_valid);
  a_r11_reset_idle: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_idx == IDX_RESET && cmd_arg != BOOT_ARG)
    |=> (state_o == ST_IDLE) && (addr_o == ADDR_DEF) && !rsp_valid);
  a_r6_addr_nonzero: assert property (@(posedge clk) disable iff (rst)
    addr_o != 16'h0000);
endmodule

// File: rtl/mmc_dev_state_ctrl.sv
module mmc_dev_state_ctrl #(
  parameter int          PWRUP_CYCLES = 1000,
  parameter int          DATA_LINES   = 8,
  parameter logic [30:0] OCR_BASE     = 31'h00FF_8080,
  parameter logic [31:0] CID_WORD     = 32'hFE01_4D4D
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_valid,
  input  logic [5:0]            cmd_idx,
  input  logic [31:0]           cmd_arg,
  input  logic                  cmd_line_low,
  output logic                  rsp_valid,
  output logic [31:0]           rsp_data,
  output logic [3:0]            state_code,
  output logic                  illegal_cmd,
  output logic [15:0]           card_addr,
  output logic [1:0]            bus_width,
  output logic [DATA_LINES-1:0] pullup_en
);
  logic pwr_done;
  logic width_set;
  logic bus_restore;

  pwrup_timer #(.CYCLES(PWRUP_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .done_o (pwr_done)
  );

  card_state_fsm #(.OCR_BASE(OCR_BASE), .CID_WORD(CID_WORD)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_idx     (cmd_idx),
    .cmd_arg     (cmd_arg),
    .line_low    (cmd_line_low),
    .pwr_done    (pwr_done),
    .state_o     (state_code),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .illegal_o   (illegal_cmd),
    .addr_o      (card_addr),
    .width_set   (width_set),
    .bus_restore (bus_restore)
  );

  bus_width_ctrl #(.LINES(DATA_LINES)) u_width (
    .clk       (clk),
    .rst       (rst),
    .restore_i (bus_restore),
    .set_i     (width_set),
    .code_i    (cmd_arg[1:0]),
    .width_o   (bus_width),
    .pullup_o  (pullup_en)
  );
endmodule

// File: tb/tb_mmc_dev_state_ctrl.sv
`timescale 1ns/1ps
module tb_mmc_dev_state_ctrl;
  localparam int PWR = 20;
  localparam logic [30:0] OCRB = 31'h00FF_8080;
  localparam logic [31:0] CIDW = 32'hFE01_4D4D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [5:0] cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic cmd_line_low = 1'b0;
  logic rsp_valid;
  logic [31:0] rsp_data;
  logic [3:0] state_code;
  logic illegal_cmd;
  logic [15:0] card_addr;
  logic [1:0] bus_width;
  logic [7:0] pullup_en;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mmc_dev_state_ctrl #(.PWRUP_CYCLES(PWR), .OCR_BASE(OCRB), .CID_WORD(CIDW)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .cmd_line_low(cmd_line_low), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .state_code(state_code), .illegal_cmd(illegal_cmd), .card_addr(card_addr),
    .bus_width(bus_width), .pullup_en(pullup_en));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [5:0] idx, input logic [31:0] arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_idx = idx; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 state", 32'(state_code), 32'd0);
    chk("R1 addr", 32'(card_addr), 32'h0001);
    chk("R1 width", 32'(bus_width), 32'd0);
    chk("R1 pullups", 32'(pullup_en), 32'hFF);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 illegal", 32'(illegal_cmd), 32'd0);
  endtask

  task automatic t_busy;
    send(6'd1, 32'h1234_5678);
    chk("R2 busy rsp", rsp_data, {1'b0, OCRB});
    chk("R3 rsp_valid", 32'(rsp_valid), 32'd1);
    chk("R2 stays idle", 32'(state_code), 32'd0);
    send(6'd2, 32'h0);
    chk("R10 illegal set", 32'(illegal_cmd), 32'd1);
    chk("R10 no rsp", 32'(rsp_valid), 32'd0);
    chk("R10 state kept", 32'(state_code), 32'd0);
    repeat (PWR + 10) @(negedge clk);
    send(6'd1, 32'hFFFF_FFFF);
    chk("R2 ready rsp", rsp_data, {1'b1, OCRB});
    chk("R2 to ready", 32'(state_code), 32'd1);
    chk("R10 illegal cleared", 32'(illegal_cmd), 32'd0);
  endtask

  task automatic t_boot_arg;
    send(6'd0, 32'hFFFF_FFFA);
    chk("R4 late boot arg resets", 32'(state_code), 32'd0);
    send(6'd0, 32'hFFFF_FFFA);
    chk("R4 boot entry", 32'(state_code), 32'd15);
    chk("R4 no rsp", 32'(rsp_valid), 32'd0);
    send(6'd1, 32'h0);
    chk("R10 cmd1 in boot", 32'(illegal_cmd), 32'd1);
    chk("R10 boot kept", 32'(state_code), 32'd15);
    send(6'd0, 32'h0);
    chk("R11 boot to idle", 32'(state_code), 32'd0);
  endtask

  task automatic t_boot_hold;
    @(negedge clk);
    cmd_line_low = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 hold boot", 32'(state_code), 32'd15);
    cmd_line_low = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 release idle", 32'(state_code), 32'd0);
  endtask

  task automatic t_ident;
    send(6'd1, 32'h0);
    chk("R2 ready again", 32'(state_code), 32'd1);
    send(6'd2, 32'h0);
    chk("R6 ident", 32'(state_code), 32'd2);
    chk("R6 cid", rsp_data, CIDW);
    send(6'd3, 32'h0000_0000);
    chk("R6 zero addr illegal", 32'(illegal_cmd), 32'd1);
    chk("R6 zero addr state", 32'(state_code), 32'd2);
    send(6'd3, 32'h0005_0000);
    chk("R6 standby", 32'(state_code), 32'd3);
    chk("R6 addr stored", 32'(card_addr), 32'h0005);
    chk("R12 status ident", rsp_data, 32'h0000_0400);
  endtask

  task automatic t_select;
    send(6'd7, 32'h0006_0000);
    chk("R7 other addr state", 32'(state_code), 32'd3);
    chk("R7 other addr no rsp", 32'(rsp_valid), 32'd0);
    chk("R7 other addr no flag", 32'(illegal_cmd), 32'd0);
    send(6'd7, 32'h0005_0000);
    chk("R7 transfer", 32'(state_code), 32'd4);
    chk("R12 status stby", rsp_data, 32'h0000_0600);
    send(6'd7, 32'h0005_0000);
    chk("R8 own addr illegal", 32'(illegal_cmd), 32'd1);
    chk("R8 own addr state", 32'(state_code), 32'd4);
  endtask

  task automatic t_width;
    send(6'd6, 32'h1);
    chk("R9 4bit", 32'(bus_width), 32'd1);
    chk("R9 4bit pullups", 32'(pullup_en), 32'hF9);
    chk("R12 status xfer", rsp_data, 32'h0000_0800);
    send(6'd6, 32'h2);
    chk("R9 8bit", 32'(bus_width), 32'd2);
    chk("R9 8bit pullups", 32'(pullup_en), 32'h09);
    send(6'd6, 32'h3);
    chk("R9 code3 illegal", 32'(illegal_cmd), 32'd1);
    chk("R9 code3 width kept", 32'(bus_width), 32'd2);
    send(6'd6, 32'h0);
    chk("R9 1bit", 32'(bus_width), 32'd0);
    chk("R9 1bit pullups", 32'(pullup_en), 32'hFF);
    send(6'd6, 32'h2);
  endtask

  task automatic t_deselect;
    send(6'd7, 32'h0000_0000);
    chk("R8 deselect zero", 32'(state_code), 32'd3);
    chk("R8 deselect rsp", 32'(rsp_valid), 32'd1);
    send(6'd6, 32'h1);
    chk("R10 width in stby", 32'(illegal_cmd), 32'd1);
    chk("R10 width kept", 32'(bus_width), 32'd2);
    send(6'd7, 32'h0005_0000);
    send(6'd7, 32'h0009_0000);
    chk("R8 other addr deselect", 32'(state_code), 32'd3);
  endtask

  task automatic t_soft_reset;
    send(6'd0, 32'h0);
    chk("R11 idle", 32'(state_code), 32'd0);
    chk("R11 addr", 32'(card_addr), 32'h0001);
    chk("R11 width", 32'(bus_width), 32'd0);
    chk("R11 pullups", 32'(pullup_en), 32'hFF);
    chk("R11 no rsp", 32'(rsp_valid), 32'd0);
    send(6'd13, 32'h0);
    chk("R10 unknown index", 32'(illegal_cmd), 32'd1);
  endtask

  initial begin
    t_reset();
    t_busy();
    t_boot_arg();
    t_boot_hold();
    t_ident();
    t_select();
    t_width();
    t_deselect();
    t_soft_reset();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule